// File: doc/BRIEF.md
# Four-Phase Bus-to-Device Handshake Sequencer

This block sits between a bus master and a slow peripheral and orders the strobe and acknowledge edges of each transfer. From idle, the master picks either a read or a write by raising the matching strobe. The sequencer then drives a strobe toward the device, an enable for the data transceiver and an acknowledge back to the bus. It follows a fixed four-phase order for each kind of transfer. In the return-to-zero half, the strobe and the bus acknowledge drop in the same cycle.

The design is clocked. On each rising edge it samples the three inputs and evaluates one next-state function for each registered output, plus one for a hidden phase bit. During a read the signal code seen at the pins repeats with different successors. The phase bit tells those two moments apart: it sets once the read strobe is high while the device acknowledge is low, and it clears when the read strobe drops.

A protocol monitor watches the inputs. It latches a sticky error when an input edge arrives out of turn, when two inputs move in one cycle, when an input moves while an output change is still owed, or when both strobes are high together.

Top module: `hs_bus_ctrl`

## Requirements
- R1: While `rst_ni` is low, `dev_stb_o`, `xcvr_en_o`, `bus_ack_o` and `proto_err_o` are all 0.
- R2: Read rise phase. The hidden phase bit sets on the first edge that samples the read strobe high. `dev_stb_o` rises one cycle after that. One cycle after the device acknowledge is sampled high, `xcvr_en_o` rises and `dev_stb_o` stays high. `bus_ack_o` rises one cycle after `xcvr_en_o`.
- R3: Read return phase. After the read strobe is sampled low, `xcvr_en_o` falls two cycles later. `dev_stb_o` and `bus_ack_o` then fall together in the following cycle.
- R4: Write rise phase. `xcvr_en_o` rises one cycle after the write strobe is sampled high, and `dev_stb_o` rises one cycle after that. One cycle after the device acknowledge is sampled high, `xcvr_en_o` falls. `bus_ack_o` rises one cycle after that fall.
- R5: Write return phase. While the write strobe stays high, `dev_stb_o` holds. One cycle after the write strobe is sampled low, `dev_stb_o` and `bus_ack_o` fall together.
- R6: Once set, `proto_err_o` stays at 1 until reset.
- R7: Both strobes sampled high in the same cycle set `proto_err_o` one cycle later.
- R8: An input edge that is not the next legal event sets `proto_err_o` one cycle later. Two examples are the device acknowledge rising while `dev_stb_o` is low, and the read strobe falling before `bus_ack_o` is high.
- R9: An input edge sampled while an output or phase-bit change is still pending sets `proto_err_o` one cycle later.
- R10: Complete read and write transfers that follow the orders of R2–R5 leave `proto_err_o` at 0 and return all outputs to 0 once the device acknowledge drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_stb_i | input | 1 | Read strobe from the bus master |
| wr_stb_i | input | 1 | Write strobe from the bus master |
| dev_ack_i | input | 1 | Acknowledge from the device |
| dev_stb_o | output | 1 | Strobe to the device |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge to the bus master |
| proto_err_o | output | 1 | Sticky protocol violation flag |

## Verification
The hardest case to reach from the pins is an input edge that lands while an output change is still owed. In this state the inputs are legal but the registers have not yet settled. Reaching it needs an input to move in the one cycle between a phase-bit change and the strobe that follows it. The bench gets there by raising the read strobe and then raising the device acknowledge on the very next edge, before the strobe has risen. It also covers the early fall of the read strobe and both strobes high together, with a reset between each violation so that the sticky flag starts clean each time.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ack;
  } hs_in_t;

  typedef struct packed {
    logic ph;    // read phase bit, separates repeated pin codes
    logic en;
    logic stb;
    logic back;
  } hs_state_t;

  localparam int unsigned HS_IN_W = $bits(hs_in_t);
  localparam int unsigned HS_ST_W = $bits(hs_state_t);

  function automatic hs_state_t hs_next(hs_in_t i, hs_state_t s);
    hs_state_t n;
    n.ph   = i.rd & (s.ph | ~i.ack);
    n.en   = (i.ack & s.ph) | (i.wr & ~i.ack & (s.en | ~s.stb));
    n.stb  = s.ph | s.en | (i.wr & s.stb);
    n.back = (s.en & ~i.wr) | (i.wr & (s.back | (i.ack & ~s.en & s.stb)));
    return n;
  endfunction

endpackage

// File: rtl/hs_seq_core.sv
`timescale 1ns/1ps
module hs_seq_core
  import hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  hs_in_t    in_i,
  output hs_state_t st_o
);

  hs_state_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= hs_next(in_i, st_q);
  end

  assign st_o = st_q;

  p_ph_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_i.rd |=> !st_q.ph);

  p_back_after_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q.back) && !$past(in_i.wr) |-> $past(st_q.en));

  p_wr_en_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_i.wr && in_i.ack && !st_q.ph |=> !st_q.en);

  p_wr_stb_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_i.wr && st_q.stb |=> st_q.stb);

endmodule

// File: rtl/hs_proto_chk.sv
`timescale 1ns/1ps
module hs_proto_chk
  import hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  hs_in_t    in_i,
  input  hs_state_t st_i,
  output logic      err_o
);

  hs_in_t in_q;
  hs_in_t chg;
  logic   err_q;
  logic   pend;
  logic   idle;
  logic   rd_ok, wr_ok, ack_ok;
  logic   viol;

  assign chg  = in_i ^ in_q;
  assign pend = (hs_next(in_q, st_i) != st_i);
  assign idle = (st_i == '0);

  always_comb begin
    rd_ok  = in_q.rd ? st_i.back : (idle & ~in_q.wr & ~in_q.ack);
    wr_ok  = in_q.wr ? st_i.back : (idle & ~in_q.rd & ~in_q.ack);
    ack_ok = in_q.ack ? (~st_i.stb & ~st_i.en & ~st_i.back)
                      : (st_i.stb & ~st_i.back & (in_q.rd | in_q.wr));
  end

  always_comb begin
    viol = in_i.rd & in_i.wr;
    if (chg != '0) begin
      if ($countones(chg) > 1 || pend) viol = 1'b1;
      if (chg.rd  && !rd_ok)  viol = 1'b1;
      if (chg.wr  && !wr_ok)  viol = 1'b1;
      if (chg.ack && !ack_ok) viol = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      err_q <= 1'b0;
    end else begin
      in_q  <= in_i;
      err_q <= err_q | viol;
    end
  end

  assign err_o = err_q;

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  p_both_strobes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_i.rd && in_i.wr |=> err_q);

endmodule

// File: rtl/hs_bus_ctrl.sv
`timescale 1ns/1ps
module hs_bus_ctrl
  import hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_stb_i,
  input  logic wr_stb_i,
  input  logic dev_ack_i,
  output logic dev_stb_o,
  output logic xcvr_en_o,
  output logic bus_ack_o,
  output logic proto_err_o
);

  hs_in_t    in_s;
  hs_state_t st_s;

  assign in_s.rd  = rd_stb_i;
  assign in_s.wr  = wr_stb_i;
  assign in_s.ack = dev_ack_i;

  hs_seq_core i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (in_s),
    .st_o   (st_s)
  );

  hs_proto_chk i_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (in_s),
    .st_i   (st_s),
    .err_o  (proto_err_o)
  );

  assign dev_stb_o = st_s.stb;
  assign xcvr_en_o = st_s.en;
  assign bus_ack_o = st_s.back;

  p_rst_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !dev_stb_o && !xcvr_en_o && !bus_ack_o && !proto_err_o);

  p_rd_stb_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ack_o) && !$past(wr_stb_i) && !$past(proto_err_o) |-> !dev_stb_o);

endmodule

// File: tb/test_hs_bus_ctrl.sv
`timescale 1ns/1ps
module test_hs_bus_ctrl;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic dev_stb, xcvr_en, bus_ack, proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] exp;
    logic [3:0] mask;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  hs_bus_ctrl i_hs_bus_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rd_stb_i    (rd),
    .wr_stb_i    (wr),
    .dev_ack_i   (ack),
    .dev_stb_o   (dev_stb),
    .xcvr_en_o   (xcvr_en),
    .bus_ack_o   (bus_ack),
    .proto_err_o (proto_err)
  );

  function automatic logic [3:0] outs();
    return {proto_err, bus_ack, dev_stb, xcvr_en};
  endfunction

  // expected vector order: {err, bus_ack, dev_stb, xcvr_en}
  task automatic step(input logic r, input logic w, input logic a,
                      input logic [3:0] e, input logic [3:0] m, input string t);
    item_t it;
    @(negedge clk);
    rd = r; wr = w; ack = a;
    it.exp = e; it.mask = m; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_ni = 1'b0; rd = 1'b0; wr = 1'b0; ack = 1'b0;
    @(negedge clk);
    checks++;
    if (outs() !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset actual=%b expected=0000", outs());
    end
    rst_ni = 1'b1;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if ((outs() & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b mask=%b", it.tag, outs(), it.exp, it.mask);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    reset_dut();

    // read transfer
    step(0,0,0, 4'b0000, 4'hF, "R1 idle");
    step(1,0,0, 4'b0000, 4'hF, "R2 phase bit only");
    step(1,0,0, 4'b0010, 4'hF, "R2 strobe up");
    step(1,0,0, 4'b0010, 4'hF, "R2 hold");
    step(1,0,1, 4'b0011, 4'hF, "R2 enable up");
    step(1,0,1, 4'b0111, 4'hF, "R2 bus ack up");
    step(1,0,1, 4'b0111, 4'hF, "R2 hold");
    step(0,0,1, 4'b0111, 4'hF, "R3 phase clears");
    step(0,0,1, 4'b0110, 4'hF, "R3 enable down");
    step(0,0,1, 4'b0000, 4'hF, "R3 strobe and ack down");
    step(0,0,0, 4'b0000, 4'hF, "R10 read done");

    // write transfer
    step(0,1,0, 4'b0001, 4'hF, "R4 enable up");
    step(0,1,0, 4'b0011, 4'hF, "R4 strobe up");
    step(0,1,0, 4'b0011, 4'hF, "R4 hold");
    step(0,1,1, 4'b0010, 4'hF, "R4 enable down");
    step(0,1,1, 4'b0110, 4'hF, "R4 bus ack up");
    step(0,1,1, 4'b0110, 4'hF, "R5 strobe holds");
    step(0,0,1, 4'b0000, 4'hF, "R5 strobe and ack down");
    step(0,0,0, 4'b0000, 4'hF, "R10 write done");
    step(0,0,0, 4'b0000, 4'hF, "R10 idle");

    // both strobes
    reset_dut();
    step(1,0,0, 4'b0000, 4'b1000, "R10 no error yet");
    step(1,1,0, 4'b1000, 4'b1000, "R7 both strobes");
    step(0,0,0, 4'b1000, 4'b1000, "R6 sticky");
    step(0,0,0, 4'b1000, 4'b1000, "R6 sticky");

    // device ack while idle
    reset_dut();
    step(0,0,1, 4'b1000, 4'b1000, "R8 ack without strobe");

    // read strobe drops early
    reset_dut();
    step(1,0,0, 4'b0000, 4'hF, "R2 phase bit only");
    step(1,0,0, 4'b0010, 4'hF, "R2 strobe up");
    step(1,0,0, 4'b0010, 4'hF, "R2 hold");
    step(0,0,0, 4'b1000, 4'b1000, "R8 early read release");

    // ack while strobe still owed
    reset_dut();
    step(1,0,0, 4'b0000, 4'hF, "R2 phase bit only");
    step(1,0,1, 4'b1000, 4'b1000, "R9 ack while pending");

    // ack while write strobe still owed
    reset_dut();
    step(0,1,0, 4'b0001, 4'hF, "R4 enable up");
    step(0,1,1, 4'b1000, 4'b1000, "R9 ack while pending");

    reset_dut();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule